// File: doc/BRIEF.md
# Coprocessor Activity Sequencer

This block is the top-level scheduler of a small coprocessor. On every clock it chooses one activity by fixed priority: a byte-copy DMA, then a pending cache preload, then instruction execution, and idle when none of these apply. The DMA is performed by the sequencer itself over a simple byte memory port. One byte is read and written per clock. For preload and execution, the sequencer only grants permission. The cache unit and the fetch unit do the actual work and report back through request and done strobes.

The host can freeze the whole coprocessor for a programmed number of cycles through a suspend request. It is told that work has finished through a sticky interrupt-pending flag. That flag is set on the clock where the unit goes from busy to not busy, for any mix of DMA, preload and execution. The host interrupt line follows the flag unless the disable input is high.

Top module: `coproc_seq`

## Requirements
- R1: After reset the unit is halted, no DMA, preload or suspend is active, the stored DMA source, target and length are 0, interrupt-pending is clear, `busy` and `irq` are 0 and `activity` is 0.
- R2: `activity` reports 4 while suspended, otherwise 1 while a DMA is active, otherwise 2 while a preload is pending, otherwise 3 while not halted, otherwise 0; at most one of `rd_en`, `preload_go` and `exec_go` is high in any cycle.
- R3: `dma_start` is sampled only in a cycle where `busy` is 0 and no suspend is active; it then stores `dma_src`, `dma_dst` and `dma_len`, and the DMA is active from the next cycle. In any other cycle it has no effect.
- R4: In the k-th transfer cycle of a DMA (k from 0), `rd_en` and `wr_en` are high, `rd_addr` is source plus k and `wr_addr` is target plus k, both modulo 2^ADDR_W, and `wr_data` equals `rd_data` in that same cycle.
- R5: A DMA of length L greater than 0 stays active for exactly L unsuspended cycles, one byte per cycle, and then clears by itself. A DMA of length 0 stays active for one cycle and makes no memory access.
- R6: `preload_req` marks a preload pending; `preload_go` is high while one is pending, no DMA is active and no suspend is active; `preload_done` in a `preload_go` cycle clears the pending preload.
- R7: `run_req` clears the halted state; `exec_go` is high when not halted, with no DMA, no preload and no suspend; `halt_req` in an `exec_go` cycle sets the halted state, and it takes priority over a `run_req` in the same cycle.
- R8: `susp_req` starts or restarts a suspend with count `susp_cycles`. A nonzero count decrements once per suspended clock, and the suspend ends on the clock where it reaches zero, so a count C keeps the unit suspended for C cycles. A count of 0 holds the suspend until the next `susp_req`.
- R9: While suspended, no DMA byte moves and the halted and preload-pending states do not change; `dma_start`, `preload_req`, `preload_done`, `run_req` and `halt_req` have no effect.
- R10: Interrupt-pending is set on the clock where `busy` goes from 1 to 0 and otherwise holds; `irq_clear` clears it, except that a set on the same clock wins.
- R11: `irq` is high exactly when interrupt-pending is set and `irq_disable` is 0.
- R12: `busy` is high when a DMA is active, a preload is pending, or the unit is not halted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dma_start | input | 1 | Host strobe to start a DMA |
| dma_src | input | ADDR_W | DMA source base address |
| dma_dst | input | ADDR_W | DMA target base address |
| dma_len | input | LEN_W | DMA length in bytes |
| preload_req | input | 1 | Cache preload request |
| preload_done | input | 1 | Cache unit reports the preload finished |
| run_req | input | 1 | Leave the halted state |
| halt_req | input | 1 | Fetch unit reports a halt |
| susp_req | input | 1 | Start or restart a suspend |
| susp_cycles | input | SUSP_W | Suspend length, 0 for indefinite |
| irq_clear | input | 1 | Clear interrupt-pending |
| irq_disable | input | 1 | Mask the host interrupt line |
| rd_en | output | 1 | DMA read strobe |
| rd_addr | output | ADDR_W | DMA read address |
| rd_data | input | DATA_W | Read data, same cycle |
| wr_en | output | 1 | DMA write strobe |
| wr_addr | output | ADDR_W | DMA write address |
| wr_data | output | DATA_W | DMA write data |
| preload_go | output | 1 | Cache unit may preload |
| exec_go | output | 1 | Fetch unit may execute |
| busy | output | 1 | Unit busy |
| irq_pending | output | 1 | Sticky interrupt-pending flag |
| irq | output | 1 | Host interrupt line |
| activity | output | 3 | Current activity code |

## Verification
The bench builds the block with ADDR_W=8, LEN_W=4, SUSP_W=3 and DATA_W=8. With 8-bit addresses, a source base near the top of the map makes a DMA wrap through address zero within a few bytes. With a 4-bit length and a 3-bit suspend count, the maximum values and the zero cases are each reached in a handful of cycles. These small widths make it practical to compare every output on every clock against the behavioural model across all the phases. This includes suspends that land in the middle of a DMA, and interrupt set and clear requests that fall on the same clock.

// File: rtl/seq_pkg.sv
package seq_pkg;

  typedef enum logic [2:0] {
    ACT_IDLE    = 3'd0,
    ACT_DMA     = 3'd1,
    ACT_PRELOAD = 3'd2,
    ACT_EXEC    = 3'd3,
    ACT_SUSPEND = 3'd4
  } seq_act_e;

  // Address of byte n of a block starting at base; callers truncate.
  function automatic logic [31:0] seq_offset(input logic [31:0] base, input logic [31:0] n);
    return base + n;
  endfunction

  function automatic logic seq_busy(input logic dma, input logic pre, input logic halted);
    return dma | pre | ~halted;
  endfunction

endpackage

// File: rtl/seq_dma.sv
module seq_dma #(
  parameter int ADDR_W = 24,
  parameter int LEN_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              freeze,
  input  logic              start,
  input  logic [ADDR_W-1:0] cfg_src,
  input  logic [ADDR_W-1:0] cfg_dst,
  input  logic [LEN_W-1:0]  cfg_len,
  output logic              xfer,
  output logic [ADDR_W-1:0] rd_addr,
  output logic [ADDR_W-1:0] wr_addr,
  output logic              active,
  output logic              active_nxt
);
  logic [ADDR_W-1:0] src_q, dst_q;
  logic [LEN_W-1:0]  len_q, idx_q;
  logic              act_q;
  logic              has_byte, last_byte;

  assign has_byte  = act_q && (idx_q != len_q);
  assign last_byte = ({1'b0, idx_q} + 1'b1) == {1'b0, len_q};
  assign xfer      = has_byte && !freeze;
  assign rd_addr   = ADDR_W'(seq_pkg::seq_offset(32'(src_q), 32'(idx_q)));
  assign wr_addr   = ADDR_W'(seq_pkg::seq_offset(32'(dst_q), 32'(idx_q)));
  assign active    = act_q;

  always_comb begin
    if (!act_q)      active_nxt = start;
    else if (freeze) active_nxt = 1'b1;
    else             active_nxt = has_byte && !last_byte;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      src_q <= '0;
      dst_q <= '0;
      len_q <= '0;
      idx_q <= '0;
      act_q <= 1'b0;
    end else begin
      act_q <= active_nxt;
      if (start && !act_q) begin
        src_q <= cfg_src;
        dst_q <= cfg_dst;
        len_q <= cfg_len;
        idx_q <= '0;
      end else if (xfer) begin
        idx_q <= idx_q + 1'b1;
      end
    end
  end

  a_r5_self_clear: assert property (@(posedge clk) disable iff (!rst_n)
    act_q && !freeze && !(has_byte && !last_byte) |=> !act_q);
  a_r9_dma_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    act_q && freeze |=> act_q && $stable(idx_q));
  a_r4_no_idle_access: assert property (@(posedge clk) disable iff (!rst_n)
    !act_q |-> !xfer);

endmodule

// File: rtl/seq_suspend.sv
module seq_suspend #(
  parameter int SUSP_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [SUSP_W-1:0] cycles,
  output logic              active
);
  logic [SUSP_W-1:0] cnt_q;
  logic              act_q;
  logic              counting, expire;

  assign counting = act_q && (cnt_q != '0);
  assign expire   = counting && (cnt_q == SUSP_W'(1));
  assign active   = act_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
      act_q <= 1'b0;
    end else if (load) begin
      cnt_q <= cycles;
      act_q <= 1'b1;
    end else if (counting) begin
      cnt_q <= cnt_q - 1'b1;
      if (expire) act_q <= 1'b0;
    end
  end

  a_r8_keeps_counting: assert property (@(posedge clk) disable iff (!rst_n)
    act_q && !load && cnt_q > SUSP_W'(1) |=> act_q);
  a_r8_releases: assert property (@(posedge clk) disable iff (!rst_n)
    act_q && !load && cnt_q == SUSP_W'(1) |=> !act_q);
  a_r8_zero_holds: assert property (@(posedge clk) disable iff (!rst_n)
    act_q && cnt_q == '0 |=> act_q);

endmodule

// File: rtl/seq_irq.sv
module seq_irq (
  input  logic clk,
  input  logic rst_n,
  input  logic busy,
  input  logic busy_nxt,
  input  logic clear,
  input  logic mask,
  output logic pending,
  output logic irq
);
  logic pend_q;
  logic went_idle;

  assign went_idle = busy && !busy_nxt;
  assign pending   = pend_q;
  assign irq       = pend_q && !mask;

  always_ff @(posedge clk) begin
    if (!rst_n)         pend_q <= 1'b0;
    else if (went_idle) pend_q <= 1'b1;
    else if (clear)     pend_q <= 1'b0;
  end

  a_r10_set_on_idle: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> pend_q);
  a_r10_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    pend_q && !clear |=> pend_q);
  a_r11_masked: assert property (@(posedge clk) disable iff (!rst_n)
    mask |-> !irq);

endmodule

// File: rtl/coproc_seq.sv
module coproc_seq #(
  parameter int ADDR_W = 24,
  parameter int LEN_W  = 16,
  parameter int SUSP_W = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              dma_start,
  input  logic [ADDR_W-1:0] dma_src,
  input  logic [ADDR_W-1:0] dma_dst,
  input  logic [LEN_W-1:0]  dma_len,
  input  logic              preload_req,
  input  logic              preload_done,
  input  logic              run_req,
  input  logic              halt_req,
  input  logic              susp_req,
  input  logic [SUSP_W-1:0] susp_cycles,
  input  logic              irq_clear,
  input  logic              irq_disable,
  output logic              rd_en,
  output logic [ADDR_W-1:0] rd_addr,
  input  logic [DATA_W-1:0] rd_data,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data,
  output logic              preload_go,
  output logic              exec_go,
  output logic              busy,
  output logic              irq_pending,
  output logic              irq,
  output logic [2:0]        activity
);
  import seq_pkg::*;

  logic halt_q, pre_q;
  logic halt_nxt, pre_nxt;
  logic suspended;
  logic dma_active, dma_nxt, dma_xfer, dma_go;
  logic busy_nxt;
  seq_act_e act;

  seq_suspend #(.SUSP_W(SUSP_W)) u_susp (
    .clk(clk), .rst_n(rst_n), .load(susp_req), .cycles(susp_cycles), .active(suspended)
  );

  assign dma_go = dma_start && !busy && !suspended;

  seq_dma #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_dma (
    .clk(clk), .rst_n(rst_n), .freeze(suspended), .start(dma_go),
    .cfg_src(dma_src), .cfg_dst(dma_dst), .cfg_len(dma_len),
    .xfer(dma_xfer), .rd_addr(rd_addr), .wr_addr(wr_addr),
    .active(dma_active), .active_nxt(dma_nxt)
  );

  assign rd_en      = dma_xfer;
  assign wr_en      = dma_xfer;
  assign wr_data    = rd_data;
  assign preload_go = pre_q && !dma_active && !suspended;
  assign exec_go    = !halt_q && !dma_active && !pre_q && !suspended;

  always_comb begin
    pre_nxt  = pre_q;
    halt_nxt = halt_q;
    if (!suspended) begin
      if (preload_go && preload_done) pre_nxt = 1'b0;
      else if (preload_req)           pre_nxt = 1'b1;
      if (exec_go && halt_req)        halt_nxt = 1'b1;
      else if (run_req)               halt_nxt = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      halt_q <= 1'b1;
      pre_q  <= 1'b0;
    end else begin
      halt_q <= halt_nxt;
      pre_q  <= pre_nxt;
    end
  end

  assign busy     = seq_busy(dma_active, pre_q, halt_q);
  assign busy_nxt = seq_busy(dma_nxt, pre_nxt, halt_nxt);

  seq_irq u_irq (
    .clk(clk), .rst_n(rst_n), .busy(busy), .busy_nxt(busy_nxt),
    .clear(irq_clear), .mask(irq_disable), .pending(irq_pending), .irq(irq)
  );

  always_comb begin
    if (suspended)       act = ACT_SUSPEND;
    else if (dma_active) act = ACT_DMA;
    else if (pre_q)      act = ACT_PRELOAD;
    else if (!halt_q)    act = ACT_EXEC;
    else                 act = ACT_IDLE;
  end
  assign activity = act;

  a_r9_state_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    suspended |=> $stable(pre_q) && $stable(halt_q));
  a_r2_one_grant: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rd_en, preload_go, exec_go}));
  a_r3_start_only_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !dma_active && (busy || suspended) |=> !dma_active);

endmodule

// File: tb/tb_coproc_seq.sv
module tb_coproc_seq;
  localparam int AW = 8, LW = 4, SW = 3, DW = 8;

  logic clk = 1'b0;
  logic rst_n;
  logic dma_start, preload_req, preload_done, run_req, halt_req, susp_req, irq_clear, irq_disable;
  logic [AW-1:0] dma_src, dma_dst;
  logic [LW-1:0] dma_len;
  logic [SW-1:0] susp_cycles;
  logic rd_en, wr_en, preload_go, exec_go, busy, irq_pending, irq;
  logic [AW-1:0] rd_addr, wr_addr;
  logic [DW-1:0] rd_data, wr_data;
  logic [2:0] activity;

  always #5 clk = ~clk;

  assign rd_data = rd_addr ^ 8'h5A;

  coproc_seq #(.ADDR_W(AW), .LEN_W(LW), .SUSP_W(SW), .DATA_W(DW)) dut (
    .clk(clk), .rst_n(rst_n), .dma_start(dma_start), .dma_src(dma_src), .dma_dst(dma_dst),
    .dma_len(dma_len), .preload_req(preload_req), .preload_done(preload_done),
    .run_req(run_req), .halt_req(halt_req), .susp_req(susp_req), .susp_cycles(susp_cycles),
    .irq_clear(irq_clear), .irq_disable(irq_disable), .rd_en(rd_en), .rd_addr(rd_addr),
    .rd_data(rd_data), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .preload_go(preload_go), .exec_go(exec_go), .busy(busy), .irq_pending(irq_pending),
    .irq(irq), .activity(activity)
  );

  int checks = 0, errors = 0;
  bit finished = 0;
  string phase = "R1";

  // reference model state
  bit m_halt, m_dma, m_pre, m_susp, m_pend;
  int m_src, m_dst, m_len, m_n, m_scnt;

  task automatic chk(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s (phase %s): actual=%0d expected=%0d", tag, what, phase, act, exp);
    end
  endtask

  function automatic bit m_busy();
    return m_dma || m_pre || !m_halt;
  endfunction

  task automatic compare();
    int e_act, e_rd, a;
    bit e_pgo, e_xgo;
    if (m_susp) e_act = 4;
    else if (m_dma) e_act = 1;
    else if (m_pre) e_act = 2;
    else if (!m_halt) e_act = 3;
    else e_act = 0;
    e_rd  = (m_dma && !m_susp && m_n < m_len) ? 1 : 0;
    e_pgo = m_pre && !m_dma && !m_susp;
    e_xgo = !m_halt && !m_dma && !m_pre && !m_susp;
    chk("R2", "activity", activity, e_act);
    chk("R12", "busy", busy, m_busy());
    chk("R6", "preload_go", preload_go, e_pgo);
    chk("R7", "exec_go", exec_go, e_xgo);
    chk("R10", "irq_pending", irq_pending, m_pend);
    chk("R11", "irq", irq, (m_pend && !irq_disable) ? 1 : 0);
    chk("R5", "rd_en", rd_en, e_rd);
    chk("R5", "wr_en", wr_en, e_rd);
    if (e_rd == 1) begin
      a = (m_src + m_n) % 256;
      chk("R4", "rd_addr", rd_addr, a);
      chk("R4", "wr_addr", wr_addr, (m_dst + m_n) % 256);
      chk("R4", "wr_data", wr_data, a ^ 'h5A);
    end
  endtask

  task automatic model_step();
    bit b0, pgo, xgo;
    b0  = m_busy();
    pgo = m_pre && !m_dma && !m_susp;
    xgo = !m_halt && !m_dma && !m_pre && !m_susp;
    if (!m_susp) begin
      if (m_dma) begin
        if (m_len - m_n <= 1) m_dma = 0;
        if (m_n < m_len) m_n++;
      end else if (!b0 && dma_start) begin
        m_src = dma_src; m_dst = dma_dst; m_len = dma_len; m_n = 0; m_dma = 1;
      end
      if (pgo && preload_done) m_pre = 0;
      else if (preload_req) m_pre = 1;
      if (xgo && halt_req) m_halt = 1;
      else if (run_req) m_halt = 0;
    end
    if (susp_req) begin
      m_susp = 1; m_scnt = susp_cycles;
    end else if (m_susp && m_scnt != 0) begin
      m_scnt--;
      if (m_scnt == 0) m_susp = 0;
    end
    if (b0 && !m_busy()) m_pend = 1;
    else if (irq_clear) m_pend = 0;
  endtask

  task automatic cyc();
    @(negedge clk); #1;
    compare();
    @(posedge clk);
    model_step();
    #1;
    dma_start = 0; preload_req = 0; preload_done = 0; run_req = 0;
    halt_req = 0; susp_req = 0; irq_clear = 0;
  endtask

  task automatic start_dma(int s, int d, int l);
    dma_src = AW'(s); dma_dst = AW'(d); dma_len = LW'(l); dma_start = 1;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 0;
    dma_start = 0; preload_req = 0; preload_done = 0; run_req = 0; halt_req = 0;
    susp_req = 0; irq_clear = 0; irq_disable = 0;
    dma_src = '0; dma_dst = '0; dma_len = '0; susp_cycles = '0;
    m_halt = 1; m_dma = 0; m_pre = 0; m_susp = 0; m_pend = 0;
    m_src = 0; m_dst = 0; m_len = 0; m_n = 0; m_scnt = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    chk("R1", "reset activity", activity, 0);
    chk("R1", "reset busy", busy, 0);
    chk("R1", "reset irq", irq, 0);
    chk("R1", "reset rd_en", rd_en, 0);
    @(posedge clk); #1;
    cyc();

    phase = "R4";  // wraps through address 0
    start_dma('hFE, 'h10, 3); cyc();
    repeat (5) cyc();
    phase = "R10"; irq_clear = 1; cyc(); cyc();

    phase = "R3";  // start while executing is ignored
    run_req = 1; cyc();
    start_dma(5, 6, 2); cyc(); cyc();
    chk("R3", "ignored start keeps exec", activity, 3);
    halt_req = 1; cyc(); repeat (2) cyc();
    irq_clear = 1; cyc();

    phase = "R5";  // zero length
    start_dma(1, 2, 0); cyc(); repeat (3) cyc();
    irq_clear = 1; cyc();

    phase = "R5";  // maximum length
    start_dma('hF8, 'h80, 15); cyc(); repeat (17) cyc();
    irq_clear = 1; cyc();

    phase = "R6";
    start_dma(3, 'h40, 4); cyc();
    preload_req = 1; cyc();
    repeat (4) cyc();
    preload_done = 1; cyc(); cyc();
    irq_clear = 1; cyc();

    phase = "R8";
    start_dma('h20, 'h30, 5); cyc(); cyc();
    susp_req = 1; susp_cycles = 3; cyc();
    phase = "R9";
    dma_start = 1; run_req = 1; preload_req = 1; cyc();
    chk("R9", "dma frozen", activity, 4);
    repeat (7) cyc();
    irq_clear = 1; cyc();

    phase = "R8";  // zero count holds
    susp_req = 1; susp_cycles = 0; cyc();
    repeat (4) cyc();
    phase = "R9"; run_req = 1; cyc();
    chk("R8", "still suspended", activity, 4);
    phase = "R8"; susp_req = 1; susp_cycles = 2; cyc();
    repeat (4) cyc();

    phase = "R11";
    irq_disable = 1; run_req = 1; cyc();
    halt_req = 1; cyc(); cyc();
    irq_disable = 0; cyc(); cyc();

    phase = "R10";  // set wins over clear
    run_req = 1; cyc();
    halt_req = 1; irq_clear = 1; cyc(); cyc();
    irq_clear = 1; cyc(); cyc();

    phase = "R7";  // halt wins over run
    run_req = 1; cyc();
    halt_req = 1; run_req = 1; cyc(); cyc();

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule